// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on the write path between a host port that delivers one 32-bit dword per write and a set of internal registers that are 128 bits wide. It assembles the dwords of one wide register in a collector and issues a single commit of the whole 128-bit value once every dword has arrived. A window of 64-bit memory words is handled the same way with two dwords per word. Plain 32-bit registers bypass the collector and commit at once.

A small set of write-only descriptor-pointer registers follows special rules, so that host software never has to lock around them. A write to a pointer's top dword always commits. If the lower three dwords of the same pointer were not all collected, zeros are used for them. A lower-dword write to a pointer is thrown away when the collector already holds another register's dwords. One timer command register clears the collector when it is written on page 0. All per-queue registers are page-mapped: the address is the page number times an 8 KiB stride plus an offset within the page.

Each commit appears one clock after the write that completes it. It is a single-cycle pulse that carries the register's aligned byte address, its size code and its value.

Top module: `wide_reg_collector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the collector is emptied, and `commit_valid` is 0 after that edge.
- R2: For a wide-register offset (in-page offset below 0x400), the four dwords (dword n at address bits [3:2] = n) may arrive in any order. The write that supplies the last missing dword produces one commit one cycle later. The commit has `commit_size` 2, `commit_addr` set to the 16-byte-aligned address, and dword n in `commit_data[32n+31:32n]`.
- R3: No wide register commits before all four of its dwords are held. A repeated write to a dword that is already held replaces its value.
- R4: A wide-register or memory-word write to a register other than the one being collected discards the old partial data. Collection restarts with the new register.
- R5: A memory-word offset (in-page offset 0x1000 and up) collects the two dwords selected by address bit 2. When both are present it commits with `commit_size` 1, an 8-byte-aligned address, the value in bits [63:0] and zeros in bits [127:64].
- R6: A write to dword 3 of a pointer register (in-page offsets 0x800 and 0xA00, 16 bytes each) always commits that register with size 2. If dwords 0 to 2 of the same register are held, they are used. Otherwise bits [95:0] are zero.
- R7: A write to dwords 0 to 2 of a pointer register is discarded, with no commit and no change to the collector, when the collector holds dwords of a different register.
- R8: Any other in-page offset is a plain 32-bit register. Writing it commits at once with size 0, a 4-byte-aligned address and the value in bits [31:0] (other bits zero), and it leaves the collector untouched.
- R9: The timer command register (in-page offset 0x410) commits like a plain register. On page 0 it also empties the collector. On any other page it leaves the collector untouched.
- R10: The page number is the address above bit 13. Decoding uses only the in-page offset, and `commit_addr` carries the full address, page included.
- R11: `commit_valid` is high for exactly one cycle per completing write and is never high in the cycle after a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host dword write strobe, one dword per cycle |
| wr_addr | input | ADDR_W (20) | Host byte address of the dword |
| wr_data | input | 32 | Host write data |
| commit_valid | output | 1 | Single-cycle commit pulse |
| commit_addr | output | ADDR_W (20) | Aligned byte address of the committed register |
| commit_size | output | 2 | 0 dword, 1 memory word, 2 wide register |
| commit_data | output | 128 | Committed value, dword n in bits [32n+31:32n] |

## Verification
Every result of this block is due exactly one clock after the write that causes it. A commit, a silent drop and a collector clear all take effect at the edge that samples the write, and the commit pulse appears in the next cycle. The reference model in the bench consumes each write at the rising edge where the design samples it. The expected commit is compared at the following falling edge, so every cycle is checked, including the cycles where no commit is due. Per-scenario commit counts confirm that drops and invalidations removed exactly the commits they should.

// File: rtl/wcol_pkg.sv
// Shared types for the wide register write collector.
package wcol_pkg;

    // Size code carried with every commit
    typedef enum logic [1:0] {
        SZ_DWORD = 2'd0,
        SZ_QWORD = 2'd1,
        SZ_OWORD = 2'd2
    } commit_size_e;

    // Class of a host write after address decoding
    typedef enum logic [2:0] {
        CLS_OWORD = 3'd0,
        CLS_QWORD = 3'd1,
        CLS_PTR   = 3'd2,
        CLS_PLAIN = 3'd3,
        CLS_TIMER = 3'd4
    } wr_class_e;

endpackage

// File: rtl/wcol_decode.sv
// Address decoder: splits a host byte address into page and in-page offset,
// classifies the offset and returns the aligned register base and dword lane.
// Assumes the pointer offsets are 16-byte aligned and PAGE_SHIFT <= 16.
module wcol_decode
    import wcol_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int PAGE_SHIFT   = 13,
    parameter int OWORD_LIMIT  = 'h400,
    parameter int QWORD_BASE   = 'h1000,
    parameter int TIMER_OFS    = 'h410,
    parameter int NUM_PTR      = 2,
    parameter logic [NUM_PTR*16-1:0] PTR_OFS_LIST = {16'h0A00, 16'h0800}
) (
    input  logic [ADDR_W-1:0] addr,
    output wr_class_e         cls,
    output logic              page_zero,
    output logic [ADDR_W-1:0] base,
    output logic [1:0]        lane
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam logic [PAGE_SHIFT-1:0] OW_LIM = OWORD_LIMIT[PAGE_SHIFT-1:0];
    localparam logic [PAGE_SHIFT-1:0] QW_BASE = QWORD_BASE[PAGE_SHIFT-1:0];
    localparam logic [PAGE_SHIFT-3:0] TMR_DW = TIMER_OFS[PAGE_SHIFT-1:2];

    logic [PAGE_SHIFT-1:0] offset;
    logic [NUM_PTR-1:0]    ptr_hit;

    assign offset    = addr[PAGE_SHIFT-1:0];
    assign page_zero = (addr[ADDR_W-1:PAGE_SHIFT] == PAGE_W'(0));

    // One comparator per pointer register on the 16-byte granule
    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        assign ptr_hit[p] =
            (offset[PAGE_SHIFT-1:4] == PTR_OFS_LIST[p*16 +: PAGE_SHIFT] >> 4);
    end

    // Classify the offset: pointer, timer, memory word, wide, plain
    always_comb begin
        if (|ptr_hit)                          cls = CLS_PTR;
        else if (offset[PAGE_SHIFT-1:2] == TMR_DW) cls = CLS_TIMER;
        else if (offset >= QW_BASE)            cls = CLS_QWORD;
        else if (offset < OW_LIM)              cls = CLS_OWORD;
        else                                   cls = CLS_PLAIN;
    end

    // Align the base address and pick the dword lane for the class
    always_comb begin
        case (cls)
            CLS_QWORD: begin
                base = {addr[ADDR_W-1:3], 3'b000};
                lane = {1'b0, addr[2]};
            end
            CLS_OWORD, CLS_PTR: begin
                base = {addr[ADDR_W-1:4], 4'b0000};
                lane = addr[3:2];
            end
            default: begin
                base = {addr[ADDR_W-1:2], 2'b00};
                lane = 2'b00;
            end
        endcase
    end

endmodule

// File: rtl/wcol_collector.sv
// Collector state and merge logic: holds the base, width and valid-dword mask
// of one partially written register and decides, for each decoded write,
// whether to merge, commit, drop or clear. Assumes one write per cycle.
module wcol_collector
    import wcol_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_class_e         cls,
    input  logic              page_zero,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        lane,
    input  logic [31:0]       wr_data,
    output logic              fire,
    output commit_size_e      fire_size,
    output logic [ADDR_W-1:0] fire_addr,
    output logic [LANES*32-1:0] fire_data,
    output logic [LANES-1:0]  hold_mask,
    output logic              hold_match
);
    localparam int DATA_W = LANES * 32;
    localparam logic [LANES-1:0] FULL_O = {LANES{1'b1}};
    localparam logic [LANES-1:0] FULL_Q = LANES'(2'b11);

    logic [ADDR_W-1:0] c_base, n_base;
    logic              c_qword, n_qword;
    logic [LANES-1:0]  c_mask, n_mask;
    logic [DATA_W-1:0] c_data, n_data;

    logic              is_q;
    logic [LANES-1:0]  merged_mask;
    logic [DATA_W-1:0] seed, merged_data;
    logic              holding_other;

    assign is_q          = (cls == CLS_QWORD);
    assign hold_match    = (c_mask != '0) && (c_base == base) && (c_qword == is_q);
    assign holding_other = (c_mask != '0) && !hold_match;
    assign seed          = hold_match ? c_data : '0;
    assign merged_mask   = (hold_match ? c_mask : '0) | (LANES'(1) << lane);
    assign hold_mask     = c_mask;

    // Insert the incoming dword into its lane of the held value
    for (genvar i = 0; i < LANES; i++) begin : g_merge
        assign merged_data[i*32 +: 32] = (lane == 2'(i)) ? wr_data : seed[i*32 +: 32];
    end

    // Next-state and commit decision for the decoded write
    always_comb begin
        n_base    = c_base;
        n_qword   = c_qword;
        n_mask    = c_mask;
        n_data    = c_data;
        fire      = 1'b0;
        fire_size = SZ_OWORD;
        fire_addr = base;
        fire_data = merged_data;
        if (wr_en) begin
            case (cls)
                CLS_OWORD, CLS_QWORD: begin
                    if (merged_mask == (is_q ? FULL_Q : FULL_O)) begin
                        fire      = 1'b1;
                        fire_size = is_q ? SZ_QWORD : SZ_OWORD;
                        n_mask    = '0;
                        n_data    = '0;
                        n_base    = '0;
                        n_qword   = 1'b0;
                    end else begin
                        n_base  = base;
                        n_qword = is_q;
                        n_mask  = merged_mask;
                        n_data  = merged_data;
                    end
                end
                CLS_PTR: begin
                    if (lane == 2'd3) begin
                        fire      = 1'b1;
                        fire_data = (merged_mask == FULL_O) ? merged_data
                                  : {wr_data, {(DATA_W-32){1'b0}}};
                        n_mask    = '0;
                        n_data    = '0;
                        n_base    = '0;
                        n_qword   = 1'b0;
                    end else if (!holding_other) begin
                        n_base  = base;
                        n_qword = 1'b0;
                        n_mask  = merged_mask;
                        n_data  = merged_data;
                    end
                end
                default: begin
                    fire      = 1'b1;
                    fire_size = SZ_DWORD;
                    fire_data = {{(DATA_W-32){1'b0}}, wr_data};
                    if (cls == CLS_TIMER && page_zero) begin
                        n_mask  = '0;
                        n_data  = '0;
                        n_base  = '0;
                        n_qword = 1'b0;
                    end
                end
            endcase
        end
    end

    // Collector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_base  <= '0;
            c_qword <= 1'b0;
            c_mask  <= '0;
            c_data  <= '0;
        end else begin
            c_base  <= n_base;
            c_qword <= n_qword;
            c_mask  <= n_mask;
            c_data  <= n_data;
        end
    end

endmodule

// File: rtl/wide_reg_collector.sv
// Top level: decodes each host dword write, runs it through the collector
// and registers the resulting commit as a single-cycle pulse.
// Assumes at most one host dword write per clock.
module wide_reg_collector
    import wcol_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [1:0]        commit_size,
    output logic [127:0]      commit_data
);
    localparam int LANES = 4;

    wr_class_e         dec_cls;
    logic              dec_page_zero;
    logic [ADDR_W-1:0] dec_base;
    logic [1:0]        dec_lane;
    logic              fire;
    commit_size_e      fire_size;
    logic [ADDR_W-1:0] fire_addr;
    logic [127:0]      fire_data;
    logic [LANES-1:0]  hold_mask;
    logic              hold_match;

    wcol_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_decode (
        .addr      (wr_addr),
        .cls       (dec_cls),
        .page_zero (dec_page_zero),
        .base      (dec_base),
        .lane      (dec_lane)
    );

    wcol_collector #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_coll (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .cls        (dec_cls),
        .page_zero  (dec_page_zero),
        .base       (dec_base),
        .lane       (dec_lane),
        .wr_data    (wr_data),
        .fire       (fire),
        .fire_size  (fire_size),
        .fire_addr  (fire_addr),
        .fire_data  (fire_data),
        .hold_mask  (hold_mask),
        .hold_match (hold_match)
    );

    // Commit output register: one-cycle pulse with address, size and value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid <= 1'b0;
            commit_addr  <= '0;
            commit_size  <= 2'd0;
            commit_data  <= '0;
        end else begin
            commit_valid <= fire;
            commit_addr  <= fire ? fire_addr : commit_addr;
            commit_size  <= fire ? fire_size : commit_size;
            commit_data  <= fire ? fire_data : commit_data;
        end
    end

endmodule

// File: rtl/wcol_checker.sv
// Protocol checker for the wide register write collector, bound to the top.
module wcol_checker
    import wcol_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input wr_class_e         dec_cls,
    input logic              dec_page_zero,
    input logic [1:0]        dec_lane,
    input logic [3:0]        hold_mask,
    input logic              hold_match,
    input logic              commit_valid,
    input logic [1:0]        commit_size,
    input logic [ADDR_W-1:0] commit_addr
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !commit_valid); // R1

    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !commit_valid); // R11

    AST_PLAIN_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (dec_cls == CLS_PLAIN || dec_cls == CLS_TIMER))
        |=> (commit_valid && commit_size == 2'd0)); // R8

    AST_PTR_TOP_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_cls == CLS_PTR && dec_lane == 2'd3)
        |=> (commit_valid && commit_size == 2'd2 && commit_addr[3:0] == 4'd0)); // R6

    AST_PTR_DROP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_cls == CLS_PTR && dec_lane != 2'd3 && hold_mask != 4'd0 && !hold_match)
        |=> ($stable(hold_mask) && !commit_valid)); // R7

    AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_cls == CLS_TIMER && dec_page_zero) |=> (hold_mask == 4'd0)); // R9

    AST_QWORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_size == 2'd1) |-> (commit_addr[2:0] == 3'd0)); // R5

    AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_cls == CLS_PLAIN) |=> $stable(hold_mask)); // R8

endmodule

bind wide_reg_collector wcol_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .dec_cls       (dec_cls),
    .dec_page_zero (dec_page_zero),
    .dec_lane      (dec_lane),
    .hold_mask     (hold_mask),
    .hold_match    (hold_match),
    .commit_valid  (commit_valid),
    .commit_size   (commit_size),
    .commit_addr   (commit_addr)
);

// File: tb/wide_reg_collector_tb.sv
// Self-checking bench: a behavioural reference model consumes each write at
// the sampling edge; outputs are compared at every following falling edge.
module wide_reg_collector_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          commit_valid;
    logic [AW-1:0] commit_addr;
    logic [1:0]    commit_size;
    logic [127:0]  commit_data;

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    bit armed  = 0;
    bit done   = 0;
    string cur_req = "R1";

    // Reference model state
    int unsigned m_mask = 0;
    int unsigned m_base = 0;
    bit          m_q = 0;
    logic [31:0] m_dw [4];
    bit            e_valid = 0;
    logic [AW-1:0] e_addr = '0;
    logic [1:0]    e_size = '0;
    logic [127:0]  e_data = '0;

    always #2.5 clk = ~clk;

    wide_reg_collector u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit_valid(commit_valid), .commit_addr(commit_addr),
        .commit_size(commit_size), .commit_data(commit_data)
    );

    task automatic model_clear();
        m_mask = 0; m_base = 0; m_q = 0;
        foreach (m_dw[i]) m_dw[i] = '0;
    endtask

    // Reference model: one step per rising edge
    always @(posedge clk) begin
        int unsigned off, base, ln;
        bit same, pz;
        int kind; // 0 wide 1 word 2 pointer 3 plain 4 timer
        armed = 1;
        e_valid = 0;
        if (!rst_n) model_clear();
        else if (wr_en) begin
            off = wr_addr % 8192;
            pz = (wr_addr / 8192) == 0;
            if ((off & ~32'hF) == 'h800 || (off & ~32'hF) == 'hA00) kind = 2;
            else if ((off & ~32'h3) == 'h410) kind = 4;
            else if (off >= 'h1000) kind = 1;
            else if (off < 'h400) kind = 0;
            else kind = 3;
            base = (kind == 1) ? (wr_addr & ~32'h7) : (wr_addr & ~32'hF);
            ln = (kind == 1) ? ((wr_addr / 4) % 2) : ((wr_addr / 4) % 4);
            same = (m_mask != 0) && (m_base == base) && (m_q == (kind == 1));
            if (kind >= 3) begin
                e_valid = 1; e_size = 0; e_addr = AW'(wr_addr & ~32'h3);
                e_data = {96'b0, wr_data};
                if (kind == 4 && pz) model_clear();
            end else if (kind == 2 && ln == 3) begin
                e_valid = 1; e_size = 2; e_addr = AW'(base);
                if (same && m_mask == 7) e_data = {wr_data, m_dw[2], m_dw[1], m_dw[0]};
                else e_data = {wr_data, 96'b0};
                model_clear();
            end else if (kind == 2 && m_mask != 0 && !same) begin
                // dropped
            end else begin
                if (!same) begin model_clear(); m_base = base; m_q = (kind == 1); end
                m_dw[ln] = wr_data;
                m_mask = m_mask | (1 << ln);
                if (m_mask == ((kind == 1) ? 3 : 15)) begin
                    e_valid = 1; e_addr = AW'(base);
                    e_size = (kind == 1) ? 2'd1 : 2'd2;
                    e_data = {m_dw[3], m_dw[2], m_dw[1], m_dw[0]};
                    model_clear();
                end
            end
        end
    end

    // Compare the outputs with the model on every falling edge
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (commit_valid) seen++;
            if (commit_valid !== e_valid ||
                (e_valid && (commit_addr !== e_addr || commit_size !== e_size ||
                             commit_data !== e_data))) begin
                errors++;
                $display("FAIL %s: valid=%0b addr=%h size=%0d data=%h expected valid=%0b addr=%h size=%0d data=%h",
                         cur_req, commit_valid, commit_addr, commit_size, commit_data,
                         e_valid, e_addr, e_size, e_data);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic check_count(input string req, input int base_cnt, input int exp);
        checks++;
        if (seen - base_cnt != exp) begin
            errors++;
            $display("FAIL %s: commit count %0d expected %0d", req, seen - base_cnt, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        int c0;
        // R1: reset
        cur_req = "R1";
        repeat (4) @(negedge clk);
        checks++;
        if (commit_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: commit_valid=%b expected 0", commit_valid);
        end
        rst_n = 1'b1;
        idle(2);

        // R2: wide register, dwords out of order
        cur_req = "R2"; c0 = seen;
        wr('h108, 32'hA2A2_0002); wr('h100, 32'hA0A0_0000);
        wr('h10C, 32'hA3A3_0003); wr('h104, 32'hA1A1_0001);
        idle(2); check_count("R2", c0, 1);

        // R3: overwrite of a held dword, no early commit
        cur_req = "R3"; c0 = seen;
        wr('h140, 32'h1); wr('h144, 32'h2); wr('h140, 32'h1111);
        wr('h148, 32'h3); idle(1); check_count("R3", c0, 0);
        wr('h14C, 32'h4); idle(2); check_count("R3", c0, 1);

        // R4: switching register abandons partial data
        cur_req = "R4"; c0 = seen;
        wr('h180, 32'hB0); wr('h184, 32'hB1);
        wr('h1C0, 32'hC0); wr('h1C4, 32'hC1); wr('h1C8, 32'hC2); wr('h1CC, 32'hC3);
        wr('h188, 32'hB2); wr('h18C, 32'hB3);
        idle(2); check_count("R4", c0, 1);

        // R5: memory word, high dword first, abandons held wide data
        cur_req = "R5"; c0 = seen;
        wr('h100C, 32'hD1D1_D1D1); wr('h1008, 32'hD0D0_D0D0);
        wr('h1FF0, 32'hE0); wr('h1FF4, 32'hE1);
        idle(2); check_count("R5", c0, 2);

        // R6 and R10: pointer on page 2 full, page 5 top only and partial
        cur_req = "R6"; c0 = seen;
        wr('h4800, 32'hF0); wr('h4804, 32'hF1); wr('h4808, 32'hF2); wr('h480C, 32'hF3);
        wr('hAA0C, 32'h5555_0003);
        wr('hAA04, 32'h77); wr('hAA0C, 32'h5555_1003);
        idle(2); check_count("R6", c0, 3);

        // R7: lower pointer write dropped while another register is held
        cur_req = "R7"; c0 = seen;
        wr('h200, 32'h20); wr('h204, 32'h21);
        wr('h2800, 32'hDEAD); wr('h2808, 32'hBEEF);
        wr('h208, 32'h22); wr('h20C, 32'h23);
        wr('h240, 32'h40); wr('h280C, 32'h9999);
        wr('h244, 32'h41); wr('h248, 32'h42); wr('h24C, 32'h43);
        idle(2); check_count("R7", c0, 2);

        // R8: plain register commits at once, collector undisturbed
        cur_req = "R8"; c0 = seen;
        wr('h300, 32'h30); wr('h304, 32'h31);
        wr('h500, 32'h5005); wr('h6FC, 32'h6FC6);
        wr('h308, 32'h32); wr('h30C, 32'h33);
        idle(2); check_count("R8", c0, 3);

        // R9: timer on page 0 clears, on page 1 it does not
        cur_req = "R9"; c0 = seen;
        wr('h300, 32'h90); wr('h304, 32'h91);
        wr('h410, 32'h7); wr('h308, 32'h92); wr('h30C, 32'h93);
        idle(1); check_count("R9", c0, 1);
        wr('h300, 32'h94); wr('h304, 32'h95);
        idle(2); check_count("R9", c0, 2);
        wr('h300, 32'h96); wr('h304, 32'h97);
        wr('h2410, 32'h8); wr('h308, 32'h98); wr('h30C, 32'h99);
        idle(2); check_count("R9", c0, 4);

        // R10: wide register on page 7 carries its page in the address
        cur_req = "R10"; c0 = seen;
        wr('hE10C, 32'h73); wr('hE108, 32'h72); wr('hE104, 32'h71); wr('hE100, 32'h70);
        idle(2); check_count("R10", c0, 1);

        // R11: idle cycles produce no commit
        cur_req = "R11"; c0 = seen;
        idle(8); check_count("R11", c0, 0);

        finish_run();
    end

endmodule